// File: doc/BRIEF.md
# Single-Step Trace Exception Controller

This block owns the status register of a processor core as far as single-step debugging is concerned. While the trace flag in the live status word is set, every instruction that the core reports as complete causes an exception request of the trace type. When the request is raised, the live trace flag is cleared so that the handler runs without being traced, and a copy of the status word taken just before the clear is held for the core to push on the stack. That copy still has the trace flag set, so when the handler ends with a return-from-exception and the popped word is reloaded, tracing resumes.

An address error that is reported for the same completing instruction takes precedence. The block then raises an address-error request instead, still clears the live trace flag, and that instruction is never traced. The interrupt mask field and all other status bits are never touched on exception entry, so interrupts stay acceptable under the same mask inside the handler. A raised request, with its type code and stacked copy, stays put until the core acknowledges it.

Top module: `trace_exc_top`

## Requirements
- R1: After reset the live status word is 16'h0700 (trace flag bit 15 is 0, mask field bits 10:8 is 3'b111, all else 0) and no request is raised.
- R2: An instruction completion with no address error, while the live trace flag is 1 and no request is pending, raises the request on the next cycle with type code 2'b01.
- R3: On the cycle after any request is raised, the live trace flag (bit 15) reads 0.
- R4: Raising a request changes no live status bit other than bit 15; the mask field bits 10:8 keep their value.
- R5: The stacked word presented with a request equals the live status word in the cycle of the completion, so for a trace request its bit 15 is 1.
- R6: A return-from-exception strobe loads the whole live status word from the popped word on the next cycle.
- R7: An instruction completion with the address-error flag set raises a request of type 2'b10 regardless of the trace flag, and no trace request is raised for that instruction.
- R8: An instruction completion while the trace flag is 0 and no address error is reported raises no request.
- R9: A raised request holds its type code and stacked word until acknowledged, and drops on the cycle after the acknowledge.
- R10: Instruction completions and address errors that arrive while a request is pending are ignored: type code, stacked word and live status word stay as they were.
- R11: In a cycle with the return-from-exception strobe, no request is raised, even if a completion is also reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrDone | input | 1 | Strobe: one instruction completed |
| addrErr | input | 1 | Address error reported for the completing instruction |
| rteValid | input | 1 | Strobe: return-from-exception reloads the status word |
| rteWord | input | 16 | Status word popped by the return |
| excAck | input | 1 | Core has taken the pending request |
| excReq | output | 1 | Exception request |
| excType | output | 2 | Request type: 2'b01 trace, 2'b10 address error, 2'b00 none |
| stackWord | output | 16 | Status word to be pushed for the pending request |
| srLive | output | 16 | Live status register |

## Verification
The hardest situation to reach is the first instruction after a return from the trace handler faulting with an address error, because the trace flag can only be set by a return and the fault must land exactly on the next completion. The bench first enters tracing through a return, takes a trace request, acknowledges it, returns with the stacked word, and then drives the completion together with the address-error flag. It also stacks further completions on top of a pending request to show they are dropped.

// File: rtl/trace_exc_pkg.sv
package trace_exc_pkg;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'b00,
    EXC_TRACE = 2'b01,
    EXC_ADDR  = 2'b10
  } excKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRte;
    logic clearT;
    logic capture;
  } srStrobe_t;

endpackage

// File: rtl/trace_exc_ctrl.sv
module trace_exc_ctrl
  import trace_exc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      instrDone,
  input  logic      addrErr,
  input  logic      rteValid,
  input  logic      excAck,
  input  logic      tLive,
  output srStrobe_t strobe,
  output logic      excReq,
  output excKind_t  excKind
);

  logic     reqPending;
  excKind_t pendKind;
  excKind_t newKind;

  // decide what this cycle's events cause
  always_comb begin
    strobe  = '0;
    newKind = EXC_NONE;
    if (rteValid) begin
      strobe.loadRte = 1'b1;
    end else if (instrDone && !reqPending) begin
      if (addrErr) begin
        newKind        = EXC_ADDR;
        strobe.clearT  = 1'b1;
        strobe.capture = 1'b1;
      end else if (tLive) begin
        newKind        = EXC_TRACE;
        strobe.clearT  = 1'b1;
        strobe.capture = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPending <= 1'b0;
      pendKind   <= EXC_NONE;
    end else if (newKind != EXC_NONE) begin
      reqPending <= 1'b1;
      pendKind   <= newKind;
    end else if (reqPending && excAck) begin
      reqPending <= 1'b0;
      pendKind   <= EXC_NONE;
    end
  end

  assign excReq  = reqPending;
  assign excKind = pendKind;

endmodule

// File: rtl/trace_exc_dp.sv
module trace_exc_dp
  import trace_exc_pkg::*;
#(
  parameter int SR_W     = 16,
  parameter int T_POS    = 15,
  parameter int MASK_LO  = 8,
  parameter int MASK_W   = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  srStrobe_t       strobe,
  input  logic [SR_W-1:0] rteWord,
  output logic [SR_W-1:0] srLive,
  output logic [SR_W-1:0] stackWord,
  output logic            tLive
);

  // reset value: mask field all ones, everything else zero
  localparam logic [SR_W-1:0] SR_RESET =
    ((SR_W)'((1 << MASK_W) - 1)) << MASK_LO;

  logic [SR_W-1:0] srReg;
  logic [SR_W-1:0] stackReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srReg <= SR_RESET;
    end else if (strobe.loadRte) begin
      srReg <= rteWord;
    end else if (strobe.clearT) begin
      srReg[T_POS] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stackReg <= '0;
    end else if (strobe.capture) begin
      stackReg <= srReg;
    end
  end

  assign srLive    = srReg;
  assign stackWord = stackReg;
  assign tLive     = srReg[T_POS];

endmodule

// File: rtl/trace_exc_top.sv
module trace_exc_top
  import trace_exc_pkg::*;
#(
  parameter int SR_W    = 16,
  parameter int T_POS   = 15,
  parameter int MASK_LO = 8,
  parameter int MASK_W  = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instrDone,
  input  logic            addrErr,
  input  logic            rteValid,
  input  logic [SR_W-1:0] rteWord,
  input  logic            excAck,
  output logic            excReq,
  output logic [1:0]      excType,
  output logic [SR_W-1:0] stackWord,
  output logic [SR_W-1:0] srLive
);

  srStrobe_t strobe;
  excKind_t  excKind;
  logic      tLive;

  trace_exc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instrDone (instrDone),
    .addrErr   (addrErr),
    .rteValid  (rteValid),
    .excAck    (excAck),
    .tLive     (tLive),
    .strobe    (strobe),
    .excReq    (excReq),
    .excKind   (excKind)
  );

  trace_exc_dp #(
    .SR_W    (SR_W),
    .T_POS   (T_POS),
    .MASK_LO (MASK_LO),
    .MASK_W  (MASK_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rteWord   (rteWord),
    .srLive    (srLive),
    .stackWord (stackWord),
    .tLive     (tLive)
  );

  assign excType = excKind;

endmodule

// File: rtl/trace_exc_chk.sv
module trace_exc_chk #(
  parameter int SR_W    = 16,
  parameter int T_POS   = 15
) (
  input logic            clk,
  input logic            rstN,
  input logic            instrDone,
  input logic            addrErr,
  input logic            rteValid,
  input logic [SR_W-1:0] rteWord,
  input logic            excAck,
  input logic            excReq,
  input logic [1:0]      excType,
  input logic [SR_W-1:0] stackWord,
  input logic [SR_W-1:0] srLive
);

  localparam logic [SR_W-1:0] KEEP = ~((SR_W)'(1) << T_POS);

  logic accept;
  assign accept = instrDone && !excReq && !rteValid;

  p_trace_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    accept && !addrErr && srLive[T_POS] |=> excReq && excType == 2'b01);

  p_clear_t_r3: assert property (@(posedge clk) disable iff (!rstN)
    accept && (addrErr || srLive[T_POS]) |=> !srLive[T_POS]);

  p_keep_bits_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rteValid |=> (srLive & KEEP) == ($past(srLive) & KEEP));

  p_stack_copy_r5: assert property (@(posedge clk) disable iff (!rstN)
    accept && (addrErr || srLive[T_POS]) |=> stackWord == $past(srLive));

  p_rte_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    rteValid |=> srLive == $past(rteWord));

  p_addr_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    accept && addrErr |=> excType == 2'b10);

  p_no_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    !excReq && (!instrDone || rteValid || (!addrErr && !srLive[T_POS])) |=> !excReq);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    excReq && !excAck |=> excReq && $stable(excType) && $stable(stackWord));

  p_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    excReq && excAck |=> !excReq);

  p_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    excReq && !rteValid |=> $stable(srLive) && $stable(stackWord));

endmodule

bind trace_exc_top trace_exc_chk #(
  .SR_W  (SR_W),
  .T_POS (T_POS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .instrDone (instrDone),
  .addrErr   (addrErr),
  .rteValid  (rteValid),
  .rteWord   (rteWord),
  .excAck    (excAck),
  .excReq    (excReq),
  .excType   (excType),
  .stackWord (stackWord),
  .srLive    (srLive)
);

// File: tb/trace_exc_top_tb_top.sv
module trace_exc_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        instrDone, addrErr, rteValid, excAck;
  logic [15:0] rteWord;
  logic        excReq;
  logic [1:0]  excType;
  logic [15:0] stackWord, srLive;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  trace_exc_top dut_i (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .addrErr(addrErr),
    .rteValid(rteValid), .rteWord(rteWord), .excAck(excAck),
    .excReq(excReq), .excType(excType), .stackWord(stackWord), .srLive(srLive)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    instrDone = 0; addrErr = 0; rteValid = 0; excAck = 0;
  endtask

  // one clock edge, then sample at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic do_rte(input logic [15:0] w);
    rteValid = 1; rteWord = w;
    step();
  endtask

  task automatic do_ack();
    excAck = 1;
    step();
  endtask

  task automatic t_reset();
    chk("R1 srLive", srLive, 16'h0700);
    chk("R1 excReq", {15'd0, excReq}, 16'd0);
  endtask

  task automatic t_rte_enter();
    rteValid = 1; rteWord = 16'h8300; instrDone = 1;
    step();
    chk("R6 srLive", srLive, 16'h8300);
    chk("R11 no req on rte cycle", {15'd0, excReq}, 16'd0);
  endtask

  task automatic t_trace_once();
    instrDone = 1;
    step();
    chk("R2 excReq", {15'd0, excReq}, 16'd1);
    chk("R2 excType", {14'd0, excType}, 16'h0001);
    chk("R3 R4 srLive", srLive, 16'h0300);
    chk("R5 stackWord", stackWord, 16'h8300);
  endtask

  task automatic t_hold_ignore();
    step(); step();
    chk("R9 held", {15'd0, excReq}, 16'd1);
    instrDone = 1; addrErr = 1;
    step();
    chk("R10 type", {14'd0, excType}, 16'h0001);
    chk("R10 srLive", srLive, 16'h0300);
    chk("R10 stack", stackWord, 16'h8300);
    do_ack();
    chk("R9 drop", {15'd0, excReq}, 16'd0);
  endtask

  task automatic t_untraced();
    instrDone = 1;
    step();
    chk("R8 no req", {15'd0, excReq}, 16'd0);
    chk("R8 srLive", srLive, 16'h0300);
  endtask

  task automatic t_addr_first_after_return();
    do_rte(stackWord);
    chk("R6 restore", srLive, 16'h8300);
    instrDone = 1; addrErr = 1;
    step();
    chk("R7 type", {14'd0, excType}, 16'h0002);
    chk("R7 T cleared", srLive, 16'h0300);
    chk("R7 stack", stackWord, 16'h8300);
    do_ack();
    chk("R7 no trace follows", {15'd0, excReq}, 16'd0);
  endtask

  task automatic t_addr_untraced();
    instrDone = 1; addrErr = 1;
    step();
    chk("R7 type T=0", {14'd0, excType}, 16'h0002);
    chk("R5 stack T=0", stackWord, 16'h0300);
    do_ack();
  endtask

  task automatic t_other_mask();
    do_rte(16'h8512);
    instrDone = 1;
    step();
    chk("R4 srLive", srLive, 16'h0512);
    chk("R5 stack", stackWord, 16'h8512);
    chk("R2 type", {14'd0, excType}, 16'h0001);
    do_ack();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(); rteWord = '0; rstN = 0;
    @(negedge clk); @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_rte_enter();
    t_trace_once();
    t_hold_ignore();
    t_untraced();
    t_addr_first_after_return();
    t_addr_untraced();
    t_other_mask();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule